// File: doc/BRIEF.md
# Interrupt Entry Sequencer for an 8-bit CPU

This block runs the entry into reset, non-maskable interrupt (NMI) and maskable interrupt (IRQ) service for an 8-bit accumulator CPU with a 16-bit address space. It works beside an instruction engine. At each instruction boundary the engine strobes `boundary_i`. The sequencer then decides whether a service is due. If one is, it takes over the memory port. It saves the return address and the status byte on a stack held in one fixed memory page. It then reads a two-byte vector and hands the new program counter, stack pointer and status back with a one-cycle `done_o` pulse.

After reset is released, the sequencer fetches the reset vector with no stack activity. It then pulses a request that clears the engine's halted state. NMI is edge-triggered and is remembered until it is serviced. IRQ is the OR of several level sources. It is masked by the interrupt-disable flag as latched at the previous instruction boundary, not at the current one. A halted engine receives no interrupt of either kind.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released, the block reads 0xFFFC then 0xFFFD with no write. It then pulses `done_o` with `pc_o` = {[0xFFFD],[0xFFFC]}, `status_o` = 0x04, `cost_o` = 0, `kind_o` = 0 (reset), `sp_o` = `sp_i`, and a one-cycle `jam_clear_o`. While reset is held, `done_o` and `mem_we_o` are low.
- R2: An entry makes exactly three writes: PC high byte to 0x0100+SP, PC low byte to 0x0100+(SP-1), and status to 0x0100+(SP-2), with the pointer wrapping modulo 256. `sp_o` returns SP-3 modulo 256.
- R3: The pushed status byte equals `status_i` with bit 4 forced to 0 and bit 5 forced to 1.
- R4: After an entry, `status_o` equals the captured `status_i` with bit 2 (interrupt disable) set.
- R5: The new PC is read little-endian: from 0xFFFA/0xFFFB for NMI (`kind_o` = 1) and from 0xFFFE/0xFFFF for IRQ (`kind_o` = 2).
- R6: An entry keeps `busy_o` high for exactly 7 cycles. `done_o` is high in the last of them, and `cost_o` then reads 7.
- R7: A rising edge on `nmi_i` makes NMI pending. A pending NMI is taken at the next idle boundary while not halted, and taking it clears the pending state. An edge that arrives during a sequence stays pending.
- R8: When NMI and IRQ are both pending at a boundary, NMI is taken. The IRQ level is not consumed.
- R9: IRQ is masked by bit 2 of `status_i` as captured at the previous boundary, and by a mask set after reset and after every entry. A boundary that clears the flag allows IRQ only from the following boundary.
- R10: Any single bit or combination of bits of `irq_src_i` requests IRQ. A source that stays high is taken again at a later unmasked boundary.
- R11: While `jammed_i` is high, no NMI or IRQ entry starts. A pending NMI survives and is taken once the halt is released.
- R12: `boundary_i` is ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the reset-vector fetch |
| boundary_i | input | 1 | Instruction boundary strobe from the engine |
| nmi_i | input | 1 | NMI request (rising edge) |
| irq_src_i | input | N_IRQ_SRC | Level IRQ source bits |
| jammed_i | input | 1 | Engine is halted |
| pc_i | input | 16 | Return address to save |
| sp_i | input | 8 | Current stack pointer |
| status_i | input | 8 | Current status byte |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_re_o | output | 1 | Memory read strobe; data returns the next cycle |
| mem_rdata_i | input | 8 | Memory read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| kind_o | output | 2 | Service taken: 0 reset, 1 NMI, 2 IRQ |
| pc_o | output | 16 | New program counter |
| sp_o | output | 8 | New stack pointer |
| status_o | output | 8 | New status byte |
| cost_o | output | 3 | Cycle charge of the service |
| jam_clear_o | output | 1 | Clears the engine's halted state after reset |

## Verification
The hardest case to reach is the one-boundary lag of the IRQ mask: an IRQ must be refused at a boundary where the current flag is already clear but the latched flag is still set. The stimulus reaches it by holding a source high and presenting two boundaries in a row with the flag clear. Entry is expected only at the second boundary. The same lag is used to start each IRQ in a sweep over all 256 status bytes. That sweep also pushes status bytes whose current disable bit is set, which shows that only the latched copy gates the request.

// File: rtl/ies_pkg.sv
package ies_pkg;
   typedef enum logic [1:0] {
      SVC_RESET = 2'd0,
      SVC_NMI   = 2'd1,
      SVC_IRQ   = 2'd2
   } svc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_PCH,
      ST_PUSH_PCL,
      ST_PUSH_ST,
      ST_VEC_LO,
      ST_VEC_HI,
      ST_VEC_CAP,
      ST_DONE
   } seq_e;
endpackage

// File: rtl/ies_arbiter.sv
module ies_arbiter #(
   parameter int DW       = 8,
   parameter int N_SRC    = 4,
   parameter int I_BIT    = 2,
   parameter bit NMI_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             nmi_i,
   input  logic [N_SRC-1:0] irq_src_i,
   input  logic             jammed_i,
   input  logic [DW-1:0]    st_i,
   input  logic             entry_done_i,
   output logic             take_nmi_o,
   output logic             take_irq_o,
   output logic             nmi_pend_o
);
   logic nmi_q;
   logic nmi_set;
   logic irq_any;
   logic mask_q;

   if (I_BIT >= DW) begin : g_bad_ibit
      $error("ies_arbiter: I_BIT outside status width");
   end

   if (NMI_EDGE) begin : g_nmi_edge
      assign nmi_set = nmi_i & ~nmi_q;
   end else begin : g_nmi_level
      assign nmi_set = nmi_i;
   end

   if (N_SRC == 1) begin : g_one_src
      assign irq_any = irq_src_i[0];
   end else begin : g_many_src
      assign irq_any = |irq_src_i;
   end

   assign take_nmi_o = go_i & nmi_pend_o & ~jammed_i;
   assign take_irq_o = go_i & ~nmi_pend_o & irq_any & ~mask_q & ~jammed_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_q      <= 1'b0;
         nmi_pend_o <= 1'b0;
         mask_q     <= 1'b1;
      end else begin
         nmi_q      <= nmi_i;
         nmi_pend_o <= (nmi_pend_o & ~take_nmi_o) | nmi_set;
         if (entry_done_i)
            mask_q <= 1'b1;
         else if (go_i && !(take_nmi_o || take_irq_o))
            mask_q <= st_i[I_BIT];
      end
   end

   // R7: a pending NMI is only dropped by being taken
   p_nmi_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend_o && !take_nmi_o) |=> nmi_pend_o);

   // R11: a halted engine never gets an interrupt
   p_jam_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      jammed_i |-> !(take_nmi_o || take_irq_o));
endmodule

// File: rtl/ies_bus_mux.sv
module ies_bus_mux
   import ies_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int STACK_PAGE = 'h01,
   parameter int B_BIT      = 4,
   parameter int U_BIT      = 5,
   parameter int NMI_VEC    = 'hFFFA,
   parameter int RST_VEC    = 'hFFFC,
   parameter int IRQ_VEC    = 'hFFFE
) (
   input  seq_e          state_i,
   input  svc_e          kind_i,
   input  logic [DW-1:0] sp_i,
   input  logic [AW-1:0] pc_i,
   input  logic [DW-1:0] st_i,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   output logic          we_o,
   output logic          re_o
);
   localparam int            PW     = AW - DW;
   localparam logic [PW-1:0] PAGE   = PW'(STACK_PAGE);
   localparam logic [DW-1:0] ONE    = {{(DW-1){1'b0}}, 1'b1};
   localparam logic [DW-1:0] B_MASK = ONE << B_BIT;
   localparam logic [DW-1:0] U_MASK = ONE << U_BIT;

   logic [AW-1:0] vec_base;

   always_comb begin
      unique case (kind_i)
         SVC_NMI: vec_base = AW'(NMI_VEC);
         SVC_IRQ: vec_base = AW'(IRQ_VEC);
         default: vec_base = AW'(RST_VEC);
      endcase
   end

   always_comb begin
      addr_o  = {PAGE, sp_i};
      wdata_o = '0;
      we_o    = 1'b0;
      re_o    = 1'b0;
      unique case (state_i)
         ST_PUSH_PCH: begin
            we_o    = 1'b1;
            wdata_o = pc_i[AW-1 -: DW];
         end
         ST_PUSH_PCL: begin
            we_o    = 1'b1;
            wdata_o = pc_i[DW-1:0];
         end
         ST_PUSH_ST: begin
            we_o    = 1'b1;
            wdata_o = (st_i & ~B_MASK) | U_MASK;
         end
         ST_VEC_LO: begin
            re_o   = 1'b1;
            addr_o = vec_base;
         end
         ST_VEC_HI: begin
            re_o   = 1'b1;
            addr_o = vec_base + AW'(1);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import ies_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int N_IRQ_SRC  = 4,
   parameter int STACK_PAGE = 'h01,
   parameter int I_BIT      = 2,
   parameter int B_BIT      = 4,
   parameter int U_BIT      = 5,
   parameter int NMI_VEC    = 'hFFFA,
   parameter int RST_VEC    = 'hFFFC,
   parameter int IRQ_VEC    = 'hFFFE,
   parameter int ENTRY_COST = 7,
   parameter bit NMI_EDGE   = 1'b1,
   localparam int COST_W    = $clog2(ENTRY_COST + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 boundary_i,
   input  logic                 nmi_i,
   input  logic [N_IRQ_SRC-1:0] irq_src_i,
   input  logic                 jammed_i,
   input  logic [AW-1:0]        pc_i,
   input  logic [DW-1:0]        sp_i,
   input  logic [DW-1:0]        status_i,
   output logic [AW-1:0]        mem_addr_o,
   output logic                 mem_we_o,
   output logic [DW-1:0]        mem_wdata_o,
   output logic                 mem_re_o,
   input  logic [DW-1:0]        mem_rdata_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [1:0]           kind_o,
   output logic [AW-1:0]        pc_o,
   output logic [DW-1:0]        sp_o,
   output logic [DW-1:0]        status_o,
   output logic [COST_W-1:0]    cost_o,
   output logic                 jam_clear_o
);
   localparam logic [DW-1:0] I_MASK = {{(DW-1){1'b0}}, 1'b1} << I_BIT;

   if (AW != 2 * DW) begin : g_bad_width
      $error("irq_entry_seq: address must be two data words wide");
   end
   if (N_IRQ_SRC < 1) begin : g_bad_src
      $error("irq_entry_seq: need at least one IRQ source");
   end
   if (ENTRY_COST < 1) begin : g_bad_cost
      $error("irq_entry_seq: entry cost must be positive");
   end

   seq_e          state;
   svc_e          kind_r;
   svc_e          kind_q;
   logic [AW-1:0] pc_r;
   logic [DW-1:0] sp_r;
   logic [DW-1:0] st_r;
   logic [DW-1:0] lo_r;
   logic          go;
   logic          take_nmi;
   logic          take_irq;
   logic          nmi_pend;

   assign go = boundary_i && (state == ST_IDLE);

   ies_arbiter #(
      .DW(DW), .N_SRC(N_IRQ_SRC), .I_BIT(I_BIT), .NMI_EDGE(NMI_EDGE)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .go_i(go), .nmi_i(nmi_i),
      .irq_src_i(irq_src_i), .jammed_i(jammed_i), .st_i(status_i),
      .entry_done_i(state == ST_DONE),
      .take_nmi_o(take_nmi), .take_irq_o(take_irq), .nmi_pend_o(nmi_pend)
   );

   ies_bus_mux #(
      .AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE), .B_BIT(B_BIT),
      .U_BIT(U_BIT), .NMI_VEC(NMI_VEC), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
   ) u_bus (
      .state_i(state), .kind_i(kind_r), .sp_i(sp_r), .pc_i(pc_r),
      .st_i(st_r), .addr_o(mem_addr_o), .wdata_o(mem_wdata_o),
      .we_o(mem_we_o), .re_o(mem_re_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_VEC_LO;
         kind_r   <= SVC_RESET;
         kind_q   <= SVC_RESET;
         pc_r     <= '0;
         sp_r     <= '0;
         st_r     <= '0;
         lo_r     <= '0;
         pc_o     <= '0;
         sp_o     <= '0;
         status_o <= '0;
         cost_o   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (take_nmi || take_irq) begin
                  kind_r <= take_nmi ? SVC_NMI : SVC_IRQ;
                  pc_r   <= pc_i;
                  sp_r   <= sp_i;
                  st_r   <= status_i;
                  state  <= ST_PUSH_PCH;
               end
            end
            ST_PUSH_PCH: begin
               sp_r  <= sp_r - 1'b1;
               state <= ST_PUSH_PCL;
            end
            ST_PUSH_PCL: begin
               sp_r  <= sp_r - 1'b1;
               state <= ST_PUSH_ST;
            end
            ST_PUSH_ST: begin
               sp_r  <= sp_r - 1'b1;
               state <= ST_VEC_LO;
            end
            ST_VEC_LO: state <= ST_VEC_HI;
            ST_VEC_HI: begin
               lo_r  <= mem_rdata_i;
               state <= ST_VEC_CAP;
            end
            ST_VEC_CAP: begin
               pc_o   <= {mem_rdata_i, lo_r};
               kind_q <= kind_r;
               if (kind_r == SVC_RESET) begin
                  sp_o     <= sp_i;
                  status_o <= I_MASK;
                  cost_o   <= '0;
               end else begin
                  sp_o     <= sp_r;
                  status_o <= st_r | I_MASK;
                  cost_o   <= COST_W'(ENTRY_COST);
               end
               state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_DONE);
   assign kind_o      = kind_q;
   assign jam_clear_o = done_o && (kind_q == SVC_RESET);

   // R2: stack writes stay in the stack page
   p_stack_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_addr_o[AW-1:DW] == (AW-DW)'(STACK_PAGE)));

   // R2: successive pushes step the pointer downward
   p_stack_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[DW-1:0] == $past(mem_addr_o[DW-1:0]) - 1'b1));

   // R4: every interrupt leaves the disable flag set
   p_iflag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && kind_o != SVC_RESET) |-> status_o[I_BIT]);

   // R6: completion is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: an interrupt completion follows its last push by four cycles
   p_push_before_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && kind_o != SVC_RESET) |-> $past(mem_we_o, 4));

   // R8: a pending NMI wins the boundary
   p_nmi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (go && nmi_pend && !jammed_i) |=>
      (state == ST_PUSH_PCH && kind_r == SVC_NMI));

   // R12: boundaries during a sequence start nothing
   p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary = 1'b0;
   logic        nmi = 1'b0;
   logic [3:0]  irq_src = 4'h0;
   logic        jam = 1'b0;
   logic [15:0] pc_in = 16'h0;
   logic [7:0]  sp_in = 8'h0;
   logic [7:0]  st_in = 8'h0;
   logic [15:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic        mem_re;
   logic [7:0]  mem_rdata = 8'h00;
   logic        busy, done, jclr;
   logic [1:0]  kind;
   logic [15:0] pc_out;
   logic [7:0]  sp_out, st_out;
   logic [2:0]  cost;

   logic [15:0] v_rst = 16'hC123;
   logic [15:0] v_nmi = 16'h8000;
   logic [15:0] v_irq = 16'h9000;

   int nchk = 0;
   int nerr = 0;
   int wcnt = 0;
   int bcnt = 0;
   int dcnt = 0;
   logic [15:0] wa [8];
   logic [7:0]  wd [8];
   logic [15:0] c_pc;
   logic [7:0]  c_sp, c_st;
   logic [1:0]  c_kind;
   logic [2:0]  c_cost;
   logic        c_jclr;

   always #5 clk = ~clk;

   irq_entry_seq u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .nmi_i(nmi),
      .irq_src_i(irq_src), .jammed_i(jam), .pc_i(pc_in), .sp_i(sp_in),
      .status_i(st_in), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
      .mem_wdata_o(mem_wdata), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
      .busy_o(busy), .done_o(done), .kind_o(kind), .pc_o(pc_out),
      .sp_o(sp_out), .status_o(st_out), .cost_o(cost), .jam_clear_o(jclr)
   );

   function automatic logic [7:0] vbyte(input logic [15:0] a);
      case (a)
         16'hFFFA: return v_nmi[7:0];
         16'hFFFB: return v_nmi[15:8];
         16'hFFFC: return v_rst[7:0];
         16'hFFFD: return v_rst[15:8];
         16'hFFFE: return v_irq[7:0];
         16'hFFFF: return v_irq[15:8];
         default:  return 8'hEA;
      endcase
   endfunction

   always @(posedge clk) if (mem_re) mem_rdata <= vbyte(mem_addr);

   always @(negedge clk) begin
      if (mem_we === 1'b1 && wcnt < 8) begin
         wa[wcnt] = mem_addr;
         wd[wcnt] = mem_wdata;
         wcnt++;
      end
      if (busy === 1'b1) bcnt++;
      if (done === 1'b1) begin
         dcnt++;
         c_pc = pc_out; c_sp = sp_out; c_st = st_out;
         c_kind = kind; c_cost = cost; c_jclr = jclr;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clr();
      wcnt = 0; bcnt = 0; dcnt = 0;
   endtask

   task automatic pulse_nmi();
      nmi = 1'b1; tick(); nmi = 1'b0; tick();
   endtask

   task automatic pulse_boundary();
      boundary = 1'b1; tick(); boundary = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 16 && dcnt == 0; i++) tick();
      tick();
   endtask

   // boundary expected to start nothing
   task automatic no_entry(input string req);
      clr();
      pulse_boundary();
      repeat (4) tick();
      chk(bcnt == 0 && wcnt == 0, req, bcnt, 0);
   endtask

   task automatic do_entry(input logic [1:0] ekind, input string req);
      logic [7:0]  sp0 = sp_in;
      logic [7:0]  st0 = st_in;
      logic [15:0] pc0 = pc_in;
      logic [15:0] vec = (ekind == 2'd1) ? v_nmi : v_irq;
      clr();
      pulse_boundary();
      wait_done();
      chk(dcnt == 1, {req, " done"}, dcnt, 1);
      chk(c_kind == ekind, {req, " R5 kind"}, c_kind, ekind);
      chk(wcnt == 3, "R2 write count", wcnt, 3);
      chk(wa[0] == {8'h01, sp0} && wd[0] == pc0[15:8], "R2 push pch",
          {wa[0], wd[0]}, {8'h01, sp0, pc0[15:8]});
      chk(wa[1] == {8'h01, 8'(sp0 - 8'd1)} && wd[1] == pc0[7:0], "R2 push pcl",
          {wa[1], wd[1]}, {8'h01, 8'(sp0 - 8'd1), pc0[7:0]});
      chk(wa[2] == {8'h01, 8'(sp0 - 8'd2)}, "R2 push status addr",
          wa[2], {8'h01, 8'(sp0 - 8'd2)});
      chk(wd[2] == ((st0 & 8'hEF) | 8'h20), "R3 pushed status",
          wd[2], (st0 & 8'hEF) | 8'h20);
      chk(c_sp == 8'(sp0 - 8'd3), "R2 sp out", c_sp, 8'(sp0 - 8'd3));
      chk(c_st == (st0 | 8'h04), "R4 status out", c_st, st0 | 8'h04);
      chk(c_pc == vec, "R5 vector pc", c_pc, vec);
      chk(c_cost == 3'd7 && bcnt == 7, "R6 cost and busy",
          {c_cost, 8'(bcnt)}, {3'd7, 8'd7});
   endtask

   // clear the latched mask with a quiet boundary
   task automatic open_mask();
      logic [7:0] keep = st_in;
      logic [3:0] ks = irq_src;
      irq_src = 4'h0;
      st_in = keep & 8'hFB;
      no_entry("R9 quiet boundary");
      st_in = keep;
      irq_src = ks;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      sp_in = 8'hFD; st_in = 8'h00;
      repeat (3) tick();
      chk(done == 1'b0 && mem_we == 1'b0, "R1 reset state", {done, mem_we}, 0);
      clr();
      rst_n = 1'b1;
      wait_done();
      chk(dcnt == 1 && c_kind == 2'd0, "R1 reset done", {8'(dcnt), c_kind}, {8'd1, 2'd0});
      chk(c_pc == v_rst, "R1 reset vector", c_pc, v_rst);
      chk(c_st == 8'h04 && c_sp == 8'hFD, "R1 reset status/sp", {c_st, c_sp}, 16'h04FD);
      chk(c_cost == 3'd0 && c_jclr == 1'b1 && wcnt == 0, "R1 cost/jam clear/no write",
          {c_cost, c_jclr, 8'(wcnt)}, {3'd0, 1'b1, 8'd0});

      // R9: mask latched at the previous boundary still blocks
      irq_src = 4'h1; st_in = 8'h00; sp_in = 8'h40; pc_in = 16'h1234;
      no_entry("R9 lagged mask");
      do_entry(2'd2, "R9 irq after open");
      irq_src = 4'h0;

      // NMI sweep over status and pointer values
      for (int s = 0; s < 256; s++) begin
         sp_in = 8'(s); st_in = 8'(255 - s);
         pc_in = {8'(s), 8'(~s)} ^ 16'h1234;
         v_nmi = 16'hA000 + 16'(s * 7);
         pulse_nmi();
         do_entry(2'd1, "R7 nmi sweep");
      end

      // IRQ sweep over all status bytes and source patterns (R10)
      for (int s = 0; s < 256; s++) begin
         sp_in = 8'(~s); st_in = 8'(s);
         pc_in = 16'(s * 257) ^ 16'h0F0F;
         v_irq = 16'h5000 + 16'(s * 13);
         irq_src = (s % 8 == 7) ? 4'hF : 4'(1 << (s % 4));
         open_mask();
         do_entry(2'd2, "R10 irq sweep");
         irq_src = 4'h0;
      end

      // R8: both pending, NMI first, IRQ level survives
      st_in = 8'h00; sp_in = 8'h80; pc_in = 16'hBEEF;
      open_mask();
      irq_src = 4'h2;
      pulse_nmi();
      do_entry(2'd1, "R8 nmi wins");
      no_entry("R8 mask after nmi");
      do_entry(2'd2, "R8 irq later");
      irq_src = 4'h0;

      // R11: halted core ignores both, NMI kept
      open_mask();
      jam = 1'b1; irq_src = 4'h1;
      pulse_nmi();
      no_entry("R11 jammed");
      jam = 1'b0; irq_src = 4'h0;
      do_entry(2'd1, "R11 nmi after jam");
      no_entry("R7 pending cleared");

      // R12: boundary during a sequence ignored, new edge held (R7)
      pulse_nmi();
      clr();
      pulse_boundary();
      tick();
      nmi = 1'b1; boundary = 1'b1; tick();
      nmi = 1'b0; boundary = 1'b0;
      wait_done();
      repeat (3) tick();
      chk(wcnt == 3 && dcnt == 1 && bcnt == 7, "R12 single sequence",
          {8'(wcnt), 8'(dcnt), 8'(bcnt)}, {8'd3, 8'd1, 8'd7});
      do_entry(2'd1, "R7 edge during busy");

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule